// File: doc/BRIEF.md
# Dual-Port Hardware Token Semaphore Bank

This block gives two independent ports a shared set of eight token flags, kept apart from any data storage. A port asks for a flag by writing a zero to it and gives it back by writing a one. It then reads the flag to learn whether it holds the token. A read returns all zeros to the side that holds the token and all ones to any side that does not. Each flag keeps one pending-request latch for each side. When the holder releases a flag and the other side has a request waiting, the token passes to the waiting side in the same update.

Each port is a synchronous bus with active-low strobes: a semaphore select, a chip enable, two lane enables, a write strobe and an output enable, together with an address, a write bus and a read bus. Writes take effect on the clock edge where the port's access is legal and its write strobe is low. The read bus is latched when the read window opens and holds that value for as long as the window stays open. Software that polls a flag must therefore close and reopen the window to see a new value.

Top module: `sem_bank`

## Requirements
- R1: After a synchronous active-low reset, both read buses are 16'h0000 and all eight flags are free, so the first read of any flag from either side returns 16'hFFFF.
- R2: A zero written to a free flag gives that side the token. From the next cycle, reads of the flag return 16'h0000 on the writing side and 16'hFFFF on the other side.
- R3: Only write-bus bit 0 has any effect, and only address bits [2:0] select the flag (index 0 to 7). All other address and data bits are ignored.
- R4: A zero written by the side that does not hold the token is stored as a pending request and does not change what either side reads. When the holder later writes a one, the token moves to the waiting side.
- R5: When the holder writes a one and the other side has no pending request, the flag becomes free and reads 16'hFFFF on both sides.
- R6: A one written by the side without the token clears that side's pending request. A later release by the holder then frees the flag.
- R7: The two sides never hold the same flag at once. When both sides write zero to the same free flag in the same cycle, the left side gets the token and the right side's request stays pending.
- R8: The read window is open while the access is legal and the output enable is low. On the first cycle the window is open, the read bus loads the addressed flag value replicated over 16 bits. That value holds, even if the flag or the address changes, until the window closes. While the window is closed the read bus is 16'h0000.
- R9: Access is legal only when the select is low and either the chip enable is high or both lane enables are high. In any other combination, writes are ignored and no read value is captured.
- R10: A write to one flag leaves the other seven flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| l_sel_n | input | 1 | Left semaphore select, active low |
| l_ce_n | input | 1 | Left chip enable, active low (must be high for semaphore access unless both lanes are off) |
| l_we_n | input | 1 | Left write strobe, active low |
| l_oe_n | input | 1 | Left output enable, active low |
| l_hb_n | input | 1 | Left high-lane enable, active low |
| l_lb_n | input | 1 | Left low-lane enable, active low |
| l_addr | input | 14 | Left address; bits [2:0] pick the flag |
| l_wdata | input | 16 | Left write bus; bit 0 carries the request value |
| l_rdata | output | 16 | Left latched read bus |
| r_sel_n | input | 1 | Right semaphore select, active low |
| r_ce_n | input | 1 | Right chip enable, active low |
| r_we_n | input | 1 | Right write strobe, active low |
| r_oe_n | input | 1 | Right output enable, active low |
| r_hb_n | input | 1 | Right high-lane enable, active low |
| r_lb_n | input | 1 | Right low-lane enable, active low |
| r_addr | input | 14 | Right address; bits [2:0] pick the flag |
| r_wdata | input | 16 | Right write bus; bit 0 carries the request value |
| r_rdata | output | 16 | Right latched read bus |

## Verification
Directed sequences go through every ownership change: claim a free flag, queue a request behind the holder, hand over on release, withdraw a request, and free the flag. Each step tells apart a design that hands over the token from one that frees the flag. Same-cycle requests from both sides separate the left-priority rule from an arbitrary pick. A write issued while the read window stays open shows whether the read bus is held or passes values through. Illegal enable combinations and junk upper address and data bits show whether the decode is too loose. Random single and simultaneous writes, checked against a reference model and ending in a sweep of all flags, expose any state leaking between flags.

// File: rtl/sem_pkg.sv
// Shared definitions for the semaphore bank.
// Assumes exactly two sides, left and right, sharing every flag.
package sem_pkg;
    // Token holder of one flag
    typedef enum logic [1:0] {
        TOK_FREE  = 2'd0,
        TOK_LEFT  = 2'd1,
        TOK_RIGHT = 2'd2
    } tok_t;
endpackage

// File: rtl/sem_port_dec.sv
// Port decoder: turns one side's active-low strobes into a legal-access,
// write and read-window indication, and picks out the flag index and
// request bit. Assumes inputs are synchronous to the bank clock.
module sem_port_dec #(
    parameter int ADDR_W = 14,
    parameter int DATA_W = 16,
    parameter int IDX_W  = 3
) (
    input  logic              sel_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic              hb_n,
    input  logic              lb_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              wr_en,
    output logic              wr_val,
    output logic              rd_win,
    output logic [IDX_W-1:0]  idx
);
    logic acc;
    logic unused_bits;

    // Legal semaphore access: select low, and the data array not claimed
    always_comb begin
        acc    = !sel_n && (ce_n || (hb_n && lb_n));
        wr_en  = acc && !we_n;
        wr_val = wdata[0];
        rd_win = acc && !oe_n;
        idx    = addr[IDX_W-1:0];
    end

    // Upper address bits and data bits above bit 0 have no function
    assign unused_bits = ^{addr[ADDR_W-1:IDX_W], wdata[DATA_W-1:1]};
endmodule

// File: rtl/sem_flag.sv
// One token flag with a pending-request latch per side.
// Assumes l_wr/r_wr are already qualified by flag index. A tie for a free
// flag goes to the left side; a release hands over to a waiting side.
module sem_flag
    import sem_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic l_wr,
    input  logic l_val,
    input  logic r_wr,
    input  logic r_val,
    output logic own_l,
    output logic own_r
);
    tok_t st, st_nx;
    logic pend_l, pend_r, pend_l_nx, pend_r_nx;

    // Next request latches and token holder
    always_comb begin
        pend_l_nx = l_wr ? !l_val : pend_l;
        pend_r_nx = r_wr ? !r_val : pend_r;
        case (st)
            TOK_LEFT:  st_nx = pend_l_nx ? TOK_LEFT  :
                               (pend_r_nx ? TOK_RIGHT : TOK_FREE);
            TOK_RIGHT: st_nx = pend_r_nx ? TOK_RIGHT :
                               (pend_l_nx ? TOK_LEFT  : TOK_FREE);
            default:   st_nx = pend_l_nx ? TOK_LEFT  :
                               (pend_r_nx ? TOK_RIGHT : TOK_FREE);
        endcase
    end

    // State register, all free on reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= TOK_FREE;
            pend_l <= 1'b0;
            pend_r <= 1'b0;
        end else begin
            st     <= st_nx;
            pend_l <= pend_l_nx;
            pend_r <= pend_r_nx;
        end
    end

    assign own_l = (st == TOK_LEFT);
    assign own_r = (st == TOK_RIGHT);
endmodule

// File: rtl/sem_rd_latch.sv
// Read latch for one side: loads the flag value across the whole bus on
// the first cycle of a read window, holds it while the window stays open,
// and drives zero while the window is closed.
module sem_rd_latch #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              win,
    input  logic              flag_bit,
    output logic [DATA_W-1:0] rdata
);
    logic win_q;

    // Capture on window opening, hold while open, clear when closed
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q <= 1'b0;
            rdata <= '0;
        end else begin
            win_q <= win;
            if (!win)
                rdata <= '0;
            else if (!win_q)
                rdata <= {DATA_W{flag_bit}};
        end
    end
endmodule

// File: rtl/sem_bank.sv
// Semaphore bank top: two port decoders, NFLAG token flags and two read
// latches. A flag reads 0 to its holder and 1 otherwise. Assumes both
// ports share clk; write effects are visible to windows opened next cycle.
module sem_bank #(
    parameter int NFLAG  = 8,
    parameter int ADDR_W = 14,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l_sel_n,
    input  logic              l_ce_n,
    input  logic              l_we_n,
    input  logic              l_oe_n,
    input  logic              l_hb_n,
    input  logic              l_lb_n,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    output logic [DATA_W-1:0] l_rdata,
    input  logic              r_sel_n,
    input  logic              r_ce_n,
    input  logic              r_we_n,
    input  logic              r_oe_n,
    input  logic              r_hb_n,
    input  logic              r_lb_n,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_wdata,
    output logic [DATA_W-1:0] r_rdata
);
    localparam int IDX_W = $clog2(NFLAG);

    logic             l_wr, l_val, l_win, r_wr, r_val, r_win;
    logic [IDX_W-1:0] l_idx, r_idx;
    logic [NFLAG-1:0] own_l_v, own_r_v;
    logic             l_bit, r_bit;

    sem_port_dec #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_dec_l (
        .sel_n(l_sel_n), .ce_n(l_ce_n), .we_n(l_we_n), .oe_n(l_oe_n),
        .hb_n(l_hb_n), .lb_n(l_lb_n), .addr(l_addr), .wdata(l_wdata),
        .wr_en(l_wr), .wr_val(l_val), .rd_win(l_win), .idx(l_idx)
    );

    sem_port_dec #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_dec_r (
        .sel_n(r_sel_n), .ce_n(r_ce_n), .we_n(r_we_n), .oe_n(r_oe_n),
        .hb_n(r_hb_n), .lb_n(r_lb_n), .addr(r_addr), .wdata(r_wdata),
        .wr_en(r_wr), .wr_val(r_val), .rd_win(r_win), .idx(r_idx)
    );

    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
        sem_flag u_flag (
            .clk(clk), .rst_n(rst_n),
            .l_wr(l_wr && (l_idx == IDX_W'(i))), .l_val(l_val),
            .r_wr(r_wr && (r_idx == IDX_W'(i))), .r_val(r_val),
            .own_l(own_l_v[i]), .own_r(own_r_v[i])
        );
    end

    // Active-low flag value as each side sees it
    always_comb begin
        l_bit = !own_l_v[l_idx];
        r_bit = !own_r_v[r_idx];
    end

    sem_rd_latch #(.DATA_W(DATA_W)) u_rd_l (
        .clk(clk), .rst_n(rst_n), .win(l_win), .flag_bit(l_bit), .rdata(l_rdata)
    );

    sem_rd_latch #(.DATA_W(DATA_W)) u_rd_r (
        .clk(clk), .rst_n(rst_n), .win(r_win), .flag_bit(r_bit), .rdata(r_rdata)
    );
endmodule

// File: rtl/sem_bank_chk.sv
// Property checker for sem_bank, attached by bind. Observes port strobes,
// read buses and the per-flag holder vectors.
module sem_bank_chk #(
    parameter int NFLAG  = 8,
    parameter int DATA_W = 16,
    parameter int IDX_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              l_sel_n, l_ce_n, l_we_n, l_oe_n, l_hb_n, l_lb_n,
    input logic              r_sel_n, r_ce_n, r_we_n, r_oe_n, r_hb_n, r_lb_n,
    input logic [IDX_W-1:0]  l_idx,
    input logic [IDX_W-1:0]  r_idx,
    input logic              l_bit,
    input logic [DATA_W-1:0] l_rdata,
    input logic [DATA_W-1:0] r_rdata,
    input logic [NFLAG-1:0]  own_l,
    input logic [NFLAG-1:0]  own_r
);
    logic l_ok, r_ok, l_wr, r_wr, l_win;

    // Independent view of legal access per side
    always_comb begin
        l_ok  = !l_sel_n && (l_ce_n || (l_hb_n && l_lb_n));
        r_ok  = !r_sel_n && (r_ce_n || (r_hb_n && r_lb_n));
        l_wr  = l_ok && !l_we_n;
        r_wr  = r_ok && !r_we_n;
        l_win = l_ok && !l_oe_n;
    end

    // R7
    never_both_owners_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (own_l & own_r) == '0);

    // R2
    left_claims_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (l_wr && !l_bit && !own_l[l_idx] && !own_r[l_idx]) |=> own_l[$past(l_idx)]);

    // R9
    no_write_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!l_wr && !r_wr) |=> ($stable(own_l) && $stable(own_r)));

    // R8
    read_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (l_win && $past(l_win) && $past(rst_n)) |=> $stable(l_rdata));

    // R8
    read_closed_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !l_win |=> (l_rdata == '0));

    // R8
    right_read_closed_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(r_ok && !r_oe_n) |=> (r_rdata == '0));
endmodule

bind sem_bank sem_bank_chk #(.NFLAG(NFLAG), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .l_sel_n(l_sel_n), .l_ce_n(l_ce_n), .l_we_n(l_we_n), .l_oe_n(l_oe_n),
    .l_hb_n(l_hb_n), .l_lb_n(l_lb_n),
    .r_sel_n(r_sel_n), .r_ce_n(r_ce_n), .r_we_n(r_we_n), .r_oe_n(r_oe_n),
    .r_hb_n(r_hb_n), .r_lb_n(r_lb_n),
    .l_idx(l_addr[IDX_W-1:0]), .r_idx(r_addr[IDX_W-1:0]),
    .l_bit(l_wdata[0]), .l_rdata(l_rdata), .r_rdata(r_rdata),
    .own_l(own_l_v), .own_r(own_r_v)
);

// File: tb/sem_bank_test.sv
`timescale 1ns/1ps
module sem_bank_test;
    localparam int NF = 8;
    localparam int WATCH_CYC = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        l_sel_n, l_ce_n, l_we_n, l_oe_n, l_hb_n, l_lb_n;
    logic        r_sel_n, r_ce_n, r_we_n, r_oe_n, r_hb_n, r_lb_n;
    logic [13:0] l_addr, r_addr;
    logic [15:0] l_wdata, r_wdata, l_rdata, r_rdata;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    // reference model: holder 0 free, 1 left, 2 right; pending requests
    int own_m [NF];
    bit pl_m [NF];
    bit pr_m [NF];

    always #2.5 clk = ~clk;

    sem_bank uut (
        .clk(clk), .rst_n(rst_n),
        .l_sel_n(l_sel_n), .l_ce_n(l_ce_n), .l_we_n(l_we_n), .l_oe_n(l_oe_n),
        .l_hb_n(l_hb_n), .l_lb_n(l_lb_n), .l_addr(l_addr), .l_wdata(l_wdata),
        .l_rdata(l_rdata),
        .r_sel_n(r_sel_n), .r_ce_n(r_ce_n), .r_we_n(r_we_n), .r_oe_n(r_oe_n),
        .r_hb_n(r_hb_n), .r_lb_n(r_lb_n), .r_addr(r_addr), .r_wdata(r_wdata),
        .r_rdata(r_rdata)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    function automatic bit legal(input bit s, input bit c, input bit h, input bit lo);
        return !s && (c || (h && lo));
    endfunction

    // flag value seen by a side: 0 only for the holder
    function automatic logic [15:0] seen(input bit side, input int f);
        return (own_m[f] == (side ? 2 : 1)) ? 16'h0000 : 16'hFFFF;
    endfunction

    task automatic model_step(input bit lw, input int lf, input bit lv,
                              input bit rw, input int rf, input bit rv);
        for (int i = 0; i < NF; i++) begin
            bit nl, nr;
            nl = (lw && lf == i) ? !lv : pl_m[i];
            nr = (rw && rf == i) ? !rv : pr_m[i];
            if (own_m[i] == 1)      own_m[i] = nl ? 1 : (nr ? 2 : 0);
            else if (own_m[i] == 2) own_m[i] = nr ? 2 : (nl ? 1 : 0);
            else                    own_m[i] = nl ? 1 : (nr ? 2 : 0);
            pl_m[i] = nl;
            pr_m[i] = nr;
        end
    endtask

    task automatic idle_l();
        l_sel_n = 1; l_ce_n = 1; l_we_n = 1; l_oe_n = 1; l_hb_n = 1; l_lb_n = 1;
    endtask
    task automatic idle_r();
        r_sel_n = 1; r_ce_n = 1; r_we_n = 1; r_oe_n = 1; r_hb_n = 1; r_lb_n = 1;
    endtask

    // Write with explicit enables; upper address/data bits randomised
    task automatic wr_raw(input bit side, input int f, input bit v,
                          input bit s, input bit c, input bit h, input bit lo);
        logic [13:0] a;
        logic [15:0] d;
        a = {14'($urandom) & 14'h3FF8} | 14'(f);
        d = {16'($urandom) & 16'hFFFE} | 16'(v);
        @(negedge clk);
        if (!side) begin
            l_sel_n = s; l_ce_n = c; l_hb_n = h; l_lb_n = lo; l_we_n = 0; l_addr = a; l_wdata = d;
        end else begin
            r_sel_n = s; r_ce_n = c; r_hb_n = h; r_lb_n = lo; r_we_n = 0; r_addr = a; r_wdata = d;
        end
        @(negedge clk);
        if (!side) idle_l(); else idle_r();
        if (legal(s, c, h, lo)) model_step(!side, f, v, side, f, v);
    endtask

    task automatic wr(input bit side, input int f, input bit v);
        wr_raw(side, f, v, 0, 1, 0, 0);
    endtask

    task automatic wr_both(input int lf, input bit lv, input int rf, input bit rv);
        @(negedge clk);
        l_sel_n = 0; l_we_n = 0; l_addr = 14'h1000 | 14'(lf); l_wdata = 16'h5A5A & 16'hFFFE | 16'(lv);
        r_sel_n = 0; r_we_n = 0; r_addr = 14'h2AA8 | 14'(rf); r_wdata = 16'hA5A4 | 16'(rv);
        @(negedge clk);
        idle_l(); idle_r();
        model_step(1, lf, lv, 1, rf, rv);
    endtask

    // Read one side with explicit enables, then check the closed bus
    task automatic rd_raw(input bit side, input int f, input bit s, input bit c,
                          input bit h, input bit lo, input string tag);
        logic [15:0] exp;
        exp = legal(s, c, h, lo) ? seen(side, f) : 16'h0000;
        @(negedge clk);
        if (!side) begin
            l_sel_n = s; l_ce_n = c; l_hb_n = h; l_lb_n = lo; l_oe_n = 0; l_addr = 14'(f);
        end else begin
            r_sel_n = s; r_ce_n = c; r_hb_n = h; r_lb_n = lo; r_oe_n = 0; r_addr = 14'(f);
        end
        @(negedge clk);
        chk(tag, side ? r_rdata : l_rdata, exp);
        if (!side) idle_l(); else idle_r();
        @(negedge clk);
        chk({tag, " closed R8"}, side ? r_rdata : l_rdata, 16'h0000);
    endtask

    task automatic rd_both(input int lf, input int rf, input string tag);
        @(negedge clk);
        l_sel_n = 0; l_oe_n = 0; l_addr = 14'(lf);
        r_sel_n = 0; r_oe_n = 0; r_addr = 14'(rf);
        @(negedge clk);
        chk({tag, " left"}, l_rdata, seen(0, lf));
        chk({tag, " right"}, r_rdata, seen(1, rf));
        idle_l(); idle_r();
        @(negedge clk);
    endtask

    initial begin
        #(WATCH_CYC * 5);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        idle_l(); idle_r();
        l_addr = 0; r_addr = 0; l_wdata = 0; r_wdata = 0;
        for (int i = 0; i < NF; i++) begin own_m[i] = 0; pl_m[i] = 0; pr_m[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 left bus after reset", l_rdata, 16'h0000);
        chk("R1 right bus after reset", r_rdata, 16'h0000);
        for (int i = 0; i < NF; i++) rd_both(i, i, "R1 all flags free");

        // R2 R3 claim with junk upper bits
        wr(0, 3, 0);
        rd_both(3, 3, "R2 R3 left claims flag 3");
        // R4 queued request then hand-over
        wr(1, 3, 0);
        rd_both(3, 3, "R4 right queued, no change");
        wr(0, 3, 1);
        rd_both(3, 3, "R4 hand-over to right");
        // R5 release with nothing pending
        wr(1, 3, 1);
        rd_both(3, 3, "R5 flag 3 free again");

        // R6 withdraw request
        wr(0, 5, 0);
        wr(1, 5, 0);
        wr(1, 5, 1);
        wr(0, 5, 1);
        rd_both(5, 5, "R6 withdrawn request, flag free");

        // R7 same-cycle tie
        wr_both(6, 0, 6, 0);
        rd_both(6, 6, "R7 tie goes left");
        wr(0, 6, 1);
        rd_both(6, 6, "R7 right request kept, hand-over");
        wr(1, 6, 1);

        // R8 held read window across a write and an address change
        @(negedge clk);
        l_sel_n = 0; l_oe_n = 0; l_addr = 14'd2;
        @(negedge clk);
        chk("R8 window opened on free flag", l_rdata, 16'hFFFF);
        l_we_n = 0; l_wdata = 16'h0000;
        @(negedge clk);
        l_we_n = 1;
        model_step(1, 2, 0, 0, 0, 0);
        chk("R8 held after own claim", l_rdata, 16'hFFFF);
        l_addr = 14'd0;
        @(negedge clk);
        chk("R8 held after address change", l_rdata, 16'hFFFF);
        idle_l();
        @(negedge clk);
        chk("R8 closed window", l_rdata, 16'h0000);
        rd_both(2, 2, "R8 reopened sees claim");
        wr(0, 2, 1);

        // R9 illegal enable combinations
        wr_raw(0, 4, 0, 0, 0, 0, 1);
        wr_raw(0, 4, 0, 0, 0, 1, 0);
        wr_raw(1, 4, 0, 1, 1, 1, 1);
        rd_both(4, 4, "R9 illegal writes ignored");
        rd_raw(0, 4, 0, 0, 0, 0, "R9 illegal read not captured");
        wr_raw(1, 4, 0, 0, 0, 1, 1);
        rd_raw(1, 4, 0, 0, 1, 1, "R9 lanes off access legal");
        wr(1, 4, 1);

        // Random mix, R10 cross-flag independence
        for (int k = 0; k < 400; k++) begin
            int op;
            op = int'($urandom % 4);
            case (op)
                0: wr(0, int'($urandom % NF), 1'($urandom));
                1: wr(1, int'($urandom % NF), 1'($urandom));
                2: wr_both(int'($urandom % NF), 1'($urandom), int'($urandom % NF), 1'($urandom));
                default: rd_both(int'($urandom % NF), int'($urandom % NF), "R10 random read");
            endcase
        end
        for (int i = 0; i < NF; i++) rd_both(i, i, "R10 final sweep");

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule